// File: doc/BRIEF.md
# Asynchronous Multiplexed Memory Access Sequencer

This block runs one access to an external NOR-style memory that shares a single bus for address and data, with every phase timed in system clock cycles. A requester presents a start pulse together with the direction, the address, the write data and a packed 32-bit timing word. The block latches all of these and then walks through the access phases in a fixed order. First comes address setup with the address strobe active. Then comes address hold, with the address still on the bus and the strobe released. Then comes the data phase, in which the output-enable strobe is active for a read and the write-enable strobe is active for a write. A read ends with a bus turnaround gap before the next access may begin.

The chip-select, address-strobe, output-enable and write-enable outputs are all active low. A bus-drive flag tells the pad logic when the block owns the shared lines. Read data is captured from the bus on the final cycle of the data phase. A one-cycle completion pulse marks the end of each access. While an access is in progress, further start requests and changes to the timing word are ignored.

Top module: `mux_access_seq`

## Requirements
- R1: After reset, cs_n, adv_n, oe_n and we_n are high, bus_oe is low and done is low.
- R2: The address setup phase lasts cfg_word[3:0]+1 cycles (1 to 16) and starts in the cycle after the cycle in which a start is accepted. During it, cs_n and adv_n are low, bus_oe is high and bus_out carries the address.
- R3: The address hold phase follows and lasts cfg_word[7:4]+1 cycles, with code 0 treated as 2 cycles. During it, cs_n is low, adv_n is high and the address stays driven on bus_out.
- R4: The data phase follows and lasts cfg_word[15:8]+1 cycles (2 to 256), with code 0 treated as 2 cycles. cs_n stays low for the whole phase.
- R5: In a read data phase, oe_n is low and bus_oe is low. rdata takes the value bus_in had in the last cycle of the phase, and rdata then stays unchanged until the next read.
- R6: In a write data phase, we_n is low, oe_n is high, bus_oe is high and bus_out carries the write data.
- R7: After a read only, a turnaround gap of cfg_word[19:16]+1 cycles (1 to 16) follows the data phase. During the gap, cs_n, adv_n, oe_n and we_n are high and bus_oe is low. A write has no gap.
- R8: done is high for exactly one cycle: the cycle after the last cycle of the final phase. cs_n is high in that cycle.
- R9: A start raised while an access is in progress is ignored. The running access keeps its address, direction and lengths, and no extra access follows.
- R10: The timing word is sampled only when a start is accepted. Changing it during an access does not alter that access's phase lengths.
- R11: oe_n and we_n are never low together, and adv_n is low only while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word: [3:0] setup, [7:4] hold, [15:8] data, [19:16] turnaround |
| req_start | input | 1 | Start request, accepted only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | W | Access address |
| req_wdata | input | W | Write data |
| bus_in | input | W | Value read from the shared bus |
| bus_out | output | W | Value driven onto the shared bus |
| bus_oe | output | 1 | High while the block drives the shared bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| rdata | output | W | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two cases cannot be reached by ordinary accesses from the ports: a start request or a timing-word change arriving while an access is in flight, and a capture that must happen on exactly the last data cycle. For the first case, the driver raises a second start with a different address, direction and timing word two cycles into the access. The scoreboard then confirms that the phase lengths, the bus contents and the number of completions match the first request only. For the second case, the bench model presents the expected read word on bus_in only in the final data cycle and its complement in every other cycle, so a capture one cycle early or late gives the wrong rdata. The extreme codes (all zero, and all ones, which gives a 256-cycle data phase) are covered as well.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;

  localparam int LEN_W = 9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASET,
    PH_AHLD,
    PH_DSET,
    PH_TURN
  } phase_t;

  function automatic logic [LEN_W-1:0] aset_cycles(input logic [31:0] c);
    return LEN_W'(c[3:0]) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] ahld_cycles(input logic [31:0] c);
    if (c[7:4] == 4'd0) return LEN_W'(2);
    return LEN_W'(c[7:4]) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] dset_cycles(input logic [31:0] c);
    if (c[15:8] == 8'd0) return LEN_W'(2);
    return LEN_W'(c[15:8]) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] turn_cycles(input logic [31:0] c);
    return LEN_W'(c[19:16]) + LEN_W'(1);
  endfunction

endpackage

// File: rtl/mux_seq_timer.sv
module mux_seq_timer #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_len - LEN_W'(1);
    else if (cnt != '0)  cnt <= cnt - LEN_W'(1);
  end

  assign last = (cnt == '0);

  // R2 R3 R4 R7: every phase lasts at least one cycle
  a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len != '0));

endmodule

// File: rtl/mux_seq_ctrl.sv
module mux_seq_ctrl
  import mux_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_word,
  input  logic             req_start,
  input  logic             req_write,
  input  logic [W-1:0]     req_addr,
  input  logic [W-1:0]     req_wdata,
  input  logic             tmr_last,
  output phase_t           phase,
  output logic             wr_q,
  output logic [W-1:0]     addr_q,
  output logic [W-1:0]     wdata_q,
  output logic             tmr_load,
  output logic [LEN_W-1:0] tmr_len,
  output logic             done
);
  phase_t      nxt;
  logic [31:0] cfg_q;
  logic        acc_finish;
  logic        accept;

  assign accept = (phase == PH_IDLE) && req_start;

  always_comb begin
    nxt      = phase;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (phase)
      PH_IDLE: if (req_start) begin
        nxt = PH_ASET; tmr_load = 1'b1; tmr_len = aset_cycles(cfg_word);
      end
      PH_ASET: if (tmr_last) begin
        nxt = PH_AHLD; tmr_load = 1'b1; tmr_len = ahld_cycles(cfg_q);
      end
      PH_AHLD: if (tmr_last) begin
        nxt = PH_DSET; tmr_load = 1'b1; tmr_len = dset_cycles(cfg_q);
      end
      PH_DSET: if (tmr_last) begin
        if (wr_q) nxt = PH_IDLE;
        else begin
          nxt = PH_TURN; tmr_load = 1'b1; tmr_len = turn_cycles(cfg_q);
        end
      end
      PH_TURN: if (tmr_last) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign acc_finish = (phase != PH_IDLE) && tmr_last && (nxt == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      done    <= 1'b0;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      phase <= nxt;
      done  <= acc_finish;
      if (accept) begin
        cfg_q   <= cfg_word;
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // R2 R3 R4: a phase only advances when the timer reports its last cycle
  a_r4_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !tmr_last) |=> (phase == $past(phase)));

  // R9: request fields frozen while busy
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));

  // R10: timing word frozen while busy
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(cfg_q));

  // R7: turnaround only follows reads
  a_r7_turn_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> !wr_q);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/mux_seq_pins.sv
module mux_seq_pins
  import mux_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_t       phase,
  input  logic         wr_q,
  input  logic [W-1:0] addr_q,
  input  logic [W-1:0] wdata_q,
  input  logic         tmr_last,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         mem_cs_n,
  output logic         mem_adv_n,
  output logic         mem_oe_n,
  output logic         mem_we_n,
  output logic [W-1:0] rdata
);
  logic in_addr;
  logic in_data;
  logic rd_capture;

  assign in_addr    = (phase == PH_ASET) || (phase == PH_AHLD);
  assign in_data    = (phase == PH_DSET);
  assign rd_capture = in_data && !wr_q && tmr_last;

  assign mem_cs_n  = !(in_addr || in_data);
  assign mem_adv_n = (phase != PH_ASET);
  assign mem_oe_n  = !(in_data && !wr_q);
  assign mem_we_n  = !(in_data && wr_q);
  assign bus_oe    = in_addr || (in_data && wr_q);
  assign bus_out   = in_addr ? addr_q : ((in_data && wr_q) ? wdata_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= bus_in;
  end

  // R11: strobes exclusive
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R11: address strobe only inside chip select
  a_r11_adv_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);

  // R5: bus released while memory drives it
  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !bus_oe);

  // R5: read data only changes out of the data phase end
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rdata));

endmodule

// File: rtl/mux_access_seq.sv
module mux_access_seq
  import mux_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  cfg_word,
  input  logic         req_start,
  input  logic         req_write,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         mem_cs_n,
  output logic         mem_adv_n,
  output logic         mem_oe_n,
  output logic         mem_we_n,
  output logic [W-1:0] rdata,
  output logic         done
);
  phase_t           phase;
  logic             wr_q;
  logic [W-1:0]     addr_q;
  logic [W-1:0]     wdata_q;
  logic             tmr_load;
  logic [LEN_W-1:0] tmr_len;
  logic             tmr_last;

  mux_seq_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .tmr_last(tmr_last), .phase(phase), .wr_q(wr_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .tmr_load(tmr_load), .tmr_len(tmr_len), .done(done)
  );

  mux_seq_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_len(tmr_len), .last(tmr_last)
  );

  mux_seq_pins #(.W(W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wr_q(wr_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .tmr_last(tmr_last),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .rdata(rdata)
  );

  // R8: chip select released when completion is signalled
  a_r8_cs_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_cs_n);

endmodule

// File: tb/mux_access_seq_tb.sv
module mux_access_seq_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cfg_word = '0;
  logic         req_start = 1'b0;
  logic         req_write = 1'b0;
  logic [W-1:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_oe, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, done;
  logic [W-1:0] rdata;

  always #4 clk = ~clk;

  mux_access_seq #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_start(req_start),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .rdata(rdata), .done(done)
  );

  typedef struct {
    bit           wr;
    int           la, lh, ld, lt;
    logic [W-1:0] addr, wdata, rword;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  int   dones = 0;
  int   pushed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t make_exp(input bit wr, input logic [31:0] c,
                                    input logic [W-1:0] a, input logic [W-1:0] d);
    exp_t e;
    e.wr    = wr;
    e.la    = int'(c[3:0]) + 1;
    e.lh    = (c[7:4] == 4'd0) ? 2 : int'(c[7:4]) + 1;
    e.ld    = (c[15:8] == 8'd0) ? 2 : int'(c[15:8]) + 1;
    e.lt    = wr ? 0 : int'(c[19:16]) + 1;
    e.addr  = a;
    e.wdata = d;
    e.rword = a ^ 16'h5A3C;
    return e;
  endfunction

  // driver: one access, optional mid-access disturbance (R9, R10)
  task automatic run_access(input bit wr, input logic [31:0] c,
                            input logic [W-1:0] a, input logic [W-1:0] d,
                            input bit poke);
    exp_q.push_back(make_exp(wr, c, a, d));
    pushed++;
    @(negedge clk);
    req_start = 1'b1; req_write = wr; cfg_word = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_start = 1'b1; req_write = ~wr; cfg_word = ~c;
      req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  // monitor / scoreboard
  int as_n = 0, ah_n = 0, dt_n = 0, tn_n = 0, busbad = 0;
  bit active = 0;
  bit prev_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) chk(0, "R8 done longer than one cycle", 1, 0);
      prev_done = done;
      if (mem_cs_n == 1'b0) active = 1;
      if (!mem_oe_n && !mem_we_n) busbad++;                  // R11
      if (!mem_adv_n && mem_cs_n) busbad++;                  // R11
      if (exp_q.size() != 0) begin
        if (!mem_cs_n && !mem_adv_n) begin
          as_n++;
          if (!bus_oe || bus_out !== exp_q[0].addr) busbad++;
        end else if (!mem_cs_n && mem_oe_n && mem_we_n) begin
          ah_n++;
          if (!bus_oe || bus_out !== exp_q[0].addr) busbad++;
        end else if (!mem_cs_n) begin
          dt_n++;
          if (exp_q[0].wr) begin
            if (mem_we_n || !mem_oe_n || !bus_oe || bus_out !== exp_q[0].wdata) busbad++;
          end else begin
            if (mem_oe_n || bus_oe) busbad++;
            bus_in = (dt_n == exp_q[0].ld) ? exp_q[0].rword : ~exp_q[0].rword;
          end
        end else if (active && !done) begin
          tn_n++;
          if (bus_oe || !mem_adv_n || !mem_oe_n || !mem_we_n) busbad++;
        end
      end
      if (done) begin
        dones++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", dones, pushed);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(as_n == e.la, "R2 setup cycles", as_n, e.la);
          chk(ah_n == e.lh, "R3 hold cycles", ah_n, e.lh);
          chk(dt_n == e.ld, "R4 data cycles", dt_n, e.ld);
          chk(tn_n == e.lt, "R7 turnaround cycles", tn_n, e.lt);
          chk(busbad == 0, "R6 R11 pin or bus content", busbad, 0);
          chk(mem_cs_n == 1'b1, "R8 cs high at done", int'(mem_cs_n), 1);
          if (!e.wr) chk(rdata === e.rword, "R5 read data", int'(rdata), int'(e.rword));
        end
        as_n = 0; ah_n = 0; dt_n = 0; tn_n = 0; busbad = 0; active = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 strobes idle",
        int'({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}), 15);
    chk(!bus_oe && !done, "R1 bus and done idle", int'({bus_oe, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && !bus_oe && !done, "R1 idle after release", int'(mem_cs_n), 1);

    run_access(0, 32'h0002_0431, 16'h1234, 16'h0000, 0);  // R2 R3 R4 R5 R7
    run_access(1, 32'h0002_0431, 16'h2345, 16'hBEEF, 0);  // R6 no turnaround
    run_access(0, 32'h0000_0000, 16'h00F0, 16'h0000, 0);  // R3 R4 reserved zero codes
    run_access(1, 32'h0000_0000, 16'h0F0F, 16'h1111, 0);
    run_access(0, 32'h000F_FFFF, 16'hC0DE, 16'h0000, 0);  // max codes
    run_access(1, 32'h000F_FFFF, 16'hFACE, 16'h7777, 0);
    run_access(0, 32'h0003_0210, 16'hA001, 16'h0000, 1);  // R9 R10 disturbance
    run_access(1, 32'h0005_0152, 16'hA002, 16'h5555, 1);
    for (int i = 1; i < 7; i++)
      run_access(i[0], (32'(i * 3) & 32'hF) | (32'(i * 5 % 16) << 4) |
                 (32'(i * 37 % 256) << 8) | (32'(i * 7 % 16) << 16),
                 16'(i * 16'h1357), 16'(i * 16'h0F1D), i[1]);

    repeat (10) @(negedge clk);
    chk(dones == pushed, "R9 completion count", dones, pushed);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule